// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block is the configuration-space register file of a single-function PCI target. A decoded access port selects one of 64 configuration dwords by index, with four byte enables, a write strobe and 32-bit write data. A read returns its dword on a registered read-data port one cycle later. The file holds the fixed identity values, the command register, a status register with sticky bits that clear when written with one, two memory base address registers with different window sizes, and the interrupt line and pin registers.

Event inputs from the bus logic set the status bits: address parity error, data parity error, target abort signalled and target abort received. The block drives a one-cycle system-error pulse when an address parity error arrives and both error enables are set. The command enables and both window bases are brought out for the address decoder. Bus phase sequencing, parity generation and the target handshake live elsewhere.

The access port has no back-pressure. It accepts a request in every cycle that `acc_valid` is high, and it cannot stall. Each read request yields exactly one `rd_valid` pulse in the next cycle. The consumer of read data must always be able to take it.

Top module: `pci_cfg_regfile`

## Requirements
- R1: After reset, the command register reads 0x0000, the status register reads 0x0400, the interrupt line reads 0x00, and both base address registers read 0x00000000.
- R2: Dword 0 reads {device id 0x0001, vendor id 0x151E}. Dword 2 reads {class 0x078000, revision 0x03}. Dword 3 (header type) reads zero. Dword 11 reads {0x0001, 0x151E}. Bits 15:8 of dword 15 read 0x01. Writes to these fields have no effect.
- R3: Every dword other than 0, 1, 2, 4, 5, 11 and 15 reads zero, and writes to it change nothing.
- R4: Dword 4 is the 256 KB memory window. Only bits 31:18 hold written data. After 0xFFFFFFFF is written, it reads 0xFFFC0000: bit 0 = 0 (memory space), bits 2:1 = 00 (anywhere in 32-bit space), bit 3 = 0 (not prefetchable).
- R5: Dword 5 is the 4 KB register window. Only bits 31:12 hold written data, and it reads 0xFFFFF000 after all ones are written.
- R6: The command register sits in dword 1 bits 15:0. Only bits 0 (I/O enable), 1 (memory enable), 6 (parity-error enable) and 8 (system-error enable) can be written, and all other bits read zero. The four bits are driven on their enable outputs.
- R7: The status register sits in dword 1 bits 31:16. Status bits 11, 12, 14 and 15 (dword bits 27, 28, 30 and 31) are sticky. Writing 1 clears a bit, and writing 0 leaves it unchanged.
- R8: Status bits 10:9 always read binary 10.
- R9: An address or data parity error sets status bit 15, whatever the enables hold. Target abort signalled sets bit 11, and target abort received sets bit 12.
- R10: An address parity error sets status bit 14 and pulses `serr_o` in the next cycle only when command bits 8 and 6 are both 1. Otherwise `serr_o` stays low.
- R11: Writes honour the byte enables: byte lane n covers dword bits 8n+7:8n. A write with only lane 3 enabled can clear status bits without touching the command register.
- R12: When a set event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends set.
- R13: A read request accepted in cycle t gives `rd_valid` high with the dword in cycle t+1. `rd_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, accepted every cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_index | input | 6 | Configuration dword index |
| acc_be | input | 4 | Byte enables for writes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| evt_addr_perr | input | 1 | Address parity error seen |
| evt_data_perr | input | 1 | Data parity error seen |
| evt_tabort_sig | input | 1 | Target abort signalled by this device |
| evt_tabort_rcv | input | 1 | Target abort received |
| serr_o | output | 1 | System-error pulse |
| io_en_o | output | 1 | Command I/O enable |
| mem_en_o | output | 1 | Command memory enable |
| perr_en_o | output | 1 | Command parity-error enable |
| serr_en_o | output | 1 | Command system-error enable |
| bar0_base_o | output | 32 | Memory window base address |
| bar1_base_o | output | 32 | Register window base address |
| int_line_o | output | 8 | Interrupt line value |

## Verification
The bench builds the block with its default parameters: window sizes of 2^18 and 2^12 bytes and the stated identity values. These defaults bring the exact all-ones readback patterns 0xFFFC0000 and 0xFFFFF000 within reach. The random traffic spans all 64 indices, all 16 byte-enable patterns and both enable combinations for the system-error gate. That covers partial-lane writes across the command/status boundary and error events with the gate both open and closed.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int CFG_DW  = 32;
  localparam int CFG_IXW = 6;

  localparam logic [CFG_IXW-1:0] IX_IDENT  = 6'd0;
  localparam logic [CFG_IXW-1:0] IX_CMDSTS = 6'd1;
  localparam logic [CFG_IXW-1:0] IX_CLASS  = 6'd2;
  localparam logic [CFG_IXW-1:0] IX_WIN0   = 6'd4;
  localparam logic [CFG_IXW-1:0] IX_WIN1   = 6'd5;
  localparam logic [CFG_IXW-1:0] IX_SUBSYS = 6'd11;
  localparam logic [CFG_IXW-1:0] IX_INTR   = 6'd15;

  localparam logic [15:0] CMD_WR_MASK  = 16'h0143;
  localparam logic [15:0] STS_W1C_MASK = 16'hD800;
  localparam logic [15:0] STS_FIXED    = 16'h0400;

  localparam int STS_TABORT_SIG = 11;
  localparam int STS_TABORT_RCV = 12;
  localparam int STS_SYS_ERR    = 14;
  localparam int STS_PAR_DET    = 15;

  typedef struct packed {
    logic addr_perr;
    logic data_perr;
    logic tabort_sig;
    logic tabort_rcv;
  } cfg_evt_t;

  function automatic logic [CFG_DW-1:0] lane_mask(input logic [CFG_DW/8-1:0] be);
    logic [CFG_DW-1:0] m;
    for (int i = 0; i < CFG_DW/8; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/pci_cfg_window.sv
module pci_cfg_window
  import pci_cfg_pkg::*;
#(
  parameter int   SIZE_LOG2 = 12,
  parameter logic PREFETCH  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_DW-1:0] wr_mask,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rd_word,
  output logic [CFG_DW-1:0] base
);
  localparam logic [CFG_DW-1:0] ADDR_MASK = ~((CFG_DW'(1) << SIZE_LOG2) - CFG_DW'(1));
  localparam logic [CFG_DW-1:0] LOW_BITS  = {28'd0, PREFETCH, 2'b00, 1'b0};

  logic [CFG_DW-1:0] base_q;
  logic [CFG_DW-1:0] upd;

  assign upd = wr_mask & ADDR_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (wr_en) base_q <= (base_q & ~upd) | (wdata & upd);
  end

  assign base    = base_q;
  assign rd_word = base_q | LOW_BITS;

  assert_win_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q));
endmodule

// File: rtl/pci_cfg_command.sv
module pci_cfg_command
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_mask,
  input  logic [15:0] wdata,
  output logic [15:0] cmd
);
  logic [15:0] cmd_q;
  logic [15:0] upd;

  assign upd = wr_mask & CMD_WR_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (wr_en) cmd_q <= (cmd_q & ~upd) | (wdata & upd);
  end

  assign cmd = cmd_q;

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmd_q));
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_mask,
  input  logic [15:0] wdata,
  input  cfg_evt_t    evt,
  input  logic        perr_en,
  input  logic        serr_en,
  output logic [15:0] sts,
  output logic        serr
);
  logic [15:0] sticky_q;
  logic [15:0] set_v;
  logic [15:0] clr_v;
  logic        serr_q;
  logic        sys_err_hit;

  assign sys_err_hit = evt.addr_perr & serr_en & perr_en;

  always_comb begin
    set_v = '0;
    set_v[STS_PAR_DET]    = evt.addr_perr | evt.data_perr;
    set_v[STS_SYS_ERR]    = sys_err_hit;
    set_v[STS_TABORT_SIG] = evt.tabort_sig;
    set_v[STS_TABORT_RCV] = evt.tabort_rcv;
    clr_v = wr_en ? (wdata & wr_mask & STS_W1C_MASK) : 16'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      serr_q   <= 1'b0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_v) | set_v) & STS_W1C_MASK;
      serr_q   <= sys_err_hit;
    end
  end

  assign sts  = sticky_q | STS_FIXED;
  assign serr = serr_q;

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt.tabort_sig |=> sts[STS_TABORT_SIG]);
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask[STS_TABORT_RCV] && wdata[STS_TABORT_RCV] && !evt.tabort_rcv)
      |=> !sts[STS_TABORT_RCV]);
  assert_par_det_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.addr_perr || evt.data_perr) |=> sts[STS_PAR_DET]);
  assert_serr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> $past(evt.addr_perr && serr_en && perr_en));
  assert_devsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts[10:9] == 2'b10);
endmodule

// File: rtl/pci_cfg_regfile.sv
module pci_cfg_regfile
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h151E,
  parameter logic [15:0] DEVICE_ID     = 16'h0001,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h078000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h151E,
  parameter logic [15:0] SUBSYS_ID     = 16'h0001,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter int          WIN0_LOG2     = 18,
  parameter int          WIN1_LOG2     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_we,
  input  logic [5:0]  acc_index,
  input  logic [3:0]  acc_be,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  input  logic        evt_addr_perr,
  input  logic        evt_data_perr,
  input  logic        evt_tabort_sig,
  input  logic        evt_tabort_rcv,
  output logic        serr_o,
  output logic        io_en_o,
  output logic        mem_en_o,
  output logic        perr_en_o,
  output logic        serr_en_o,
  output logic [31:0] bar0_base_o,
  output logic [31:0] bar1_base_o,
  output logic [7:0]  int_line_o
);
  localparam int NUM_WIN = 2;

  logic              wr;
  logic [CFG_DW-1:0] wmask;
  logic [15:0]       cmd;
  logic [15:0]       sts;
  logic [7:0]        int_line_q;
  logic [CFG_DW-1:0] win_rd   [NUM_WIN];
  logic [CFG_DW-1:0] win_base [NUM_WIN];
  logic [CFG_DW-1:0] rd_mux;
  logic              rd_valid_q;
  logic [CFG_DW-1:0] rd_data_q;
  cfg_evt_t          evt;

  assign wr    = acc_valid & acc_we;
  assign wmask = lane_mask(acc_be);
  assign evt   = '{addr_perr: evt_addr_perr, data_perr: evt_data_perr,
                   tabort_sig: evt_tabort_sig, tabort_rcv: evt_tabort_rcv};

  pci_cfg_command u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr && acc_index == IX_CMDSTS),
    .wr_mask (wmask[15:0]),
    .wdata   (acc_wdata[15:0]),
    .cmd     (cmd)
  );

  pci_cfg_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr && acc_index == IX_CMDSTS),
    .wr_mask (wmask[31:16]),
    .wdata   (acc_wdata[31:16]),
    .evt     (evt),
    .perr_en (cmd[6]),
    .serr_en (cmd[8]),
    .sts     (sts),
    .serr    (serr_o)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    pci_cfg_window #(
      .SIZE_LOG2 ((g == 0) ? WIN0_LOG2 : WIN1_LOG2),
      .PREFETCH  (1'b0)
    ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr && acc_index == ((g == 0) ? IX_WIN0 : IX_WIN1)),
      .wr_mask (wmask),
      .wdata   (acc_wdata),
      .rd_word (win_rd[g]),
      .base    (win_base[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) int_line_q <= '0;
    else if (wr && acc_index == IX_INTR && acc_be[0]) int_line_q <= acc_wdata[7:0];
  end

  always_comb begin
    case (acc_index)
      IX_IDENT:  rd_mux = {DEVICE_ID, VENDOR_ID};
      IX_CMDSTS: rd_mux = {sts, cmd};
      IX_CLASS:  rd_mux = {CLASS_CODE, REVISION};
      IX_WIN0:   rd_mux = win_rd[0];
      IX_WIN1:   rd_mux = win_rd[1];
      IX_SUBSYS: rd_mux = {SUBSYS_ID, SUBSYS_VENDOR};
      IX_INTR:   rd_mux = {16'h0000, INT_PIN, int_line_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc_valid & ~acc_we;
      if (acc_valid && !acc_we) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign io_en_o     = cmd[0];
  assign mem_en_o    = cmd[1];
  assign perr_en_o   = cmd[6];
  assign serr_en_o   = cmd[8];
  assign bar0_base_o = win_base[0];
  assign bar1_base_o = win_base[1];
  assign int_line_o  = int_line_q;

  assert_rd_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_we));
  assert_rd_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we) |=> rd_valid);
endmodule

// File: tb/pci_cfg_regfile_tb.sv
module pci_cfg_regfile_tb_top;
  localparam int CLK_NS = 20;
  localparam logic [31:0] W0_MASK = 32'hFFFC0000;
  localparam logic [31:0] W1_MASK = 32'hFFFFF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_we = 0;
  logic [5:0]  acc_index = 0;
  logic [3:0]  acc_be = 0;
  logic [31:0] acc_wdata = 0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        e_ap = 0, e_dp = 0, e_ts = 0, e_tr = 0;
  logic        serr_o, io_en_o, mem_en_o, perr_en_o, serr_en_o;
  logic [31:0] bar0_base_o, bar1_base_o;
  logic [7:0]  int_line_o;

  int n_tests = 0, n_fail = 0;

  logic [15:0] m_cmd, m_sts;
  logic [31:0] m_w0, m_w1;
  logic [7:0]  m_il;

  always #(CLK_NS/2) clk = ~clk;

  pci_cfg_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_index(acc_index), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .evt_addr_perr(e_ap), .evt_data_perr(e_dp), .evt_tabort_sig(e_ts), .evt_tabort_rcv(e_tr),
    .serr_o(serr_o), .io_en_o(io_en_o), .mem_en_o(mem_en_o), .perr_en_o(perr_en_o),
    .serr_en_o(serr_en_o), .bar0_base_o(bar0_base_o), .bar1_base_o(bar1_base_o),
    .int_line_o(int_line_o)
  );

  function automatic logic [31:0] bmask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] exp_word(input logic [5:0] ix);
    case (ix)
      6'd0:  return 32'h0001151E;
      6'd1:  return {m_sts, m_cmd};
      6'd2:  return 32'h07800003;
      6'd4:  return m_w0;
      6'd5:  return m_w1;
      6'd11: return 32'h0001151E;
      6'd15: return {16'h0, 8'h01, m_il};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [5:0] ix, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    m = bmask(be);
    case (ix)
      6'd1: begin
        m_cmd = (m_cmd & ~(m[15:0] & 16'h0143)) | (d[15:0] & m[15:0] & 16'h0143);
        m_sts = m_sts & ~(d[31:16] & m[31:16] & 16'hD800);
      end
      6'd4: m_w0 = (m_w0 & ~(m & W0_MASK)) | (d & m & W0_MASK);
      6'd5: m_w1 = (m_w1 & ~(m & W1_MASK)) | (d & m & W1_MASK);
      6'd15: if (be[0]) m_il = d[7:0];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] ix, input logic [3:0] be, input logic [31:0] d);
    acc_valid = 1; acc_we = 1; acc_index = ix; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_we = 0;
    model_write(ix, be, d);
  endtask

  task automatic cfg_read(input logic [5:0] ix, output logic [31:0] d);
    acc_valid = 1; acc_we = 0; acc_index = ix;
    @(negedge clk);
    acc_valid = 0;
    check("R13 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic read_check(input logic [5:0] ix, input string req);
    logic [31:0] d;
    cfg_read(ix, d);
    check(req, d, exp_word(ix));
  endtask

  task automatic pulse_evt(input logic ap, input logic dp, input logic ts, input logic tr);
    logic s;
    e_ap = ap; e_dp = dp; e_ts = ts; e_tr = tr;
    s = ap & m_cmd[8] & m_cmd[6];
    if (ap | dp) m_sts[15] = 1'b1;
    if (s) m_sts[14] = 1'b1;
    if (ts) m_sts[11] = 1'b1;
    if (tr) m_sts[12] = 1'b1;
    @(negedge clk);
    e_ap = 0; e_dp = 0; e_ts = 0; e_tr = 0;
    check("R10 serr_o", {31'd0, serr_o}, {31'd0, s});
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_cmd = 16'h0; m_sts = 16'h0400; m_w0 = 0; m_w1 = 0; m_il = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R13 idle rd_valid", {31'd0, rd_valid}, 32'd0);

    // R1 reset values
    read_check(6'd1, "R1 cmd/status reset");
    read_check(6'd4, "R1 bar0 reset");
    read_check(6'd5, "R1 bar1 reset");
    read_check(6'd15, "R1 int line reset");

    // R2 identity, writes ignored
    cfg_write(6'd0, 4'hF, 32'h12345678);
    cfg_write(6'd2, 4'hF, 32'hFFFFFFFF);
    cfg_write(6'd3, 4'hF, 32'hFFFFFFFF);
    read_check(6'd0, "R2 ident");
    read_check(6'd2, "R2 class/rev");
    read_check(6'd3, "R2 header type");
    read_check(6'd11, "R2 subsystem");

    // R3 unimplemented dwords
    cfg_write(6'd6, 4'hF, 32'hFFFFFFFF);
    cfg_write(6'd12, 4'hF, 32'hFFFFFFFF);
    read_check(6'd6, "R3 dword6");
    read_check(6'd12, "R3 expansion rom");
    read_check(6'd63, "R3 dword63");

    // R4 / R5 window sizing
    cfg_write(6'd4, 4'hF, 32'hFFFFFFFF);
    cfg_read(6'd4, d); check("R4 bar0 sizing", d, 32'hFFFC0000);
    check("R4 bar0 base out", bar0_base_o, 32'hFFFC0000);
    cfg_write(6'd5, 4'hF, 32'hFFFFFFFF);
    cfg_read(6'd5, d); check("R5 bar1 sizing", d, 32'hFFFFF000);
    check("R5 bar1 base out", bar1_base_o, 32'hFFFFF000);

    // R6 command writable bits
    cfg_write(6'd1, 4'h3, 32'h0000FFFF);
    cfg_read(6'd1, d); check("R6 cmd mask", {16'h0, d[15:0]}, 32'h00000143);
    check("R6 enables out", {28'd0, io_en_o, mem_en_o, perr_en_o, serr_en_o}, 32'hF);

    // R9/R10 events with gate open, R8 devsel
    pulse_evt(1, 0, 0, 0);
    cfg_read(6'd1, d); check("R10 status bit14 set", {16'h0, d[31:16]}, 32'h0000C400);
    check("R8 devsel", {30'd0, d[26:25]}, 32'd2);

    // R7 write zero no effect, then R11 lane3 only clears status, keeps cmd
    cfg_write(6'd1, 4'hF, 32'h00000143);
    read_check(6'd1, "R7 write zero keeps sticky");
    cfg_write(6'd1, 4'h8, 32'hFFFFFFFF);
    cfg_read(6'd1, d); check("R11 lane3 clear keeps cmd", d, 32'h04000143);

    // R10 gate closed: only perr enable
    cfg_write(6'd1, 4'h3, 32'h00000040);
    pulse_evt(1, 0, 0, 0);
    cfg_read(6'd1, d); check("R10 gated off", {16'h0, d[31:16]}, 32'h00008400);
    // R9 data parity with all enables off
    cfg_write(6'd1, 4'hF, 32'hFFFF0000);
    pulse_evt(0, 1, 1, 1);
    cfg_read(6'd1, d); check("R9 dpe/abort set", {16'h0, d[31:16]}, 32'h00009C00);

    // R12 set wins against same-cycle clear
    cfg_write(6'd1, 4'hF, 32'hFFFF0000);
    acc_valid = 1; acc_we = 1; acc_index = 6'd1; acc_be = 4'hC; acc_wdata = 32'hFFFF0000; e_ts = 1;
    @(negedge clk);
    acc_valid = 0; acc_we = 0; e_ts = 0;
    m_sts = 16'h0400 | 16'h0800;
    cfg_read(6'd1, d); check("R12 set wins", {16'h0, d[31:16]}, 32'h00000C00);

    // R1 interrupt line write
    cfg_write(6'd15, 4'hF, 32'hFFFFFF5A);
    read_check(6'd15, "R2 int pin / line");

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int k;
      logic [5:0] ix;
      k = $urandom_range(0, 9);
      ix = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'($urandom_range(0, 15));
      if (k < 4) cfg_write(ix, 4'($urandom_range(0, 15)), $urandom());
      else if (k < 8) read_check(ix, "R11 random access");
      else pulse_evt(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    read_check(6'd1, "R7 final status");
    summary();
  end
endmodule